// File: doc/BRIEF.md
# Processor Tick Timer Unit

This unit is a free-running cycle counter with a programmable match, meant to sit beside a small processor core. Software reaches it through two registers on a simple register-access port: a 32-bit count register and a mode register. The count advances once per core clock. The mode register holds a 28-bit period field, an interrupt-pending flag, an interrupt-enable flag and a 2-bit mode field. The period is compared against only the low 28 bits of the count.

Each clock, the low 28 count bits are compared with the period field. On a match the pending flag sets. What the counter then does depends on the mode. In continuous mode the counter keeps running through the match, so one counter can serve as a monotonic clock source and as a one-shot event generator at the same time. Restart mode clears the counter to zero on a match. One-shot mode freezes the counter and disables the mode. Disabled mode holds the counter still.

To program the next event, software reads the count, adds a delta, masks the sum to 28 bits, and writes it into the period field with enable and continuous mode set. To acknowledge, it writes the mode register with only the mode bits set.

Top module: `tick_timer_unit`

## Requirements
- R1: After an asynchronous active-low reset the count reads 0, the mode register reads 0 (disabled), and the interrupt request is low.
- R2: In modes 01, 10 and 11, when no match occurs, the count increases by exactly one per clock, wrapping from 0xFFFFFFFF to 0.
- R3: In mode 00 (disabled), the count holds its value and no match is detected.
- R4: A match means count bits [27:0] equal the period field (mode register bits [27:0]); the upper four count bits are ignored. In mode 11 (continuous), the count keeps incrementing through a match.
- R5: In mode 01 (restart), the count becomes 0 on the clock edge that follows a match cycle.
- R6: In mode 10 (one-shot), on a match the count holds its value and the mode field (bits [31:30]) reads back 00 from then on.
- R7: The pending flag (bit 28) sets on the edge after a match cycle whether or not interrupts are enabled. The interrupt request equals pending AND enable (bit 29).
- R8: A mode register write loads all fields, so writing 0 in bit 28 clears pending (acknowledge). If a match is detected in the same cycle, the match wins and pending ends up set.
- R9: The register select is 0 for the count and 1 for the mode register. A count write takes priority over that cycle's increment or clear, and reads return the live register value combinationally.
- R10: A period written equal to the count value held right after the write is detected, and pending sets on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the count register, 1 selects the mode register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Live read data of the selected register |
| irqReq | output | 1 | Interrupt request, pending AND enable |

## Verification
The bench places a match on a count whose upper bits are nonzero. A design that compared all 32 bits would never set pending there. It acknowledges in the very cycle a match is detected; a design that let the write win would lose that event. It also writes a period equal to the frozen count in one-shot mode, which a design with look-ahead or stale compare would miss or report twice. The bench also checks that one-shot really freezes and self-disables, that restart returns to zero rather than one, and that the 32-bit count wraps.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tickModeE;

  typedef struct packed {
    logic cntLoad;
    logic cntClear;
    logic cntInc;
    logic modeLoad;
    logic oneShotStop;
    logic pendSet;
  } tickStrobesT;

  localparam logic SEL_COUNT = 1'b0;
  localparam logic SEL_MODE  = 1'b1;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic        regWrEn,
  input  logic        regSel,
  input  tickModeE    curMode,
  input  logic        matchHit,
  output tickStrobesT strobes
);

  logic cntWr;
  logic modeWr;
  logic running;
  logic hit;
  logic stopsCount;

  always_comb begin
    cntWr      = regWrEn && (regSel == SEL_COUNT);
    modeWr     = regWrEn && (regSel == SEL_MODE);
    running    = (curMode != MODE_OFF);
    hit        = running && matchHit;
    stopsCount = hit && ((curMode == MODE_RESTART) || (curMode == MODE_ONESHOT));

    strobes             = '0;
    strobes.cntLoad     = cntWr;
    strobes.cntClear    = !cntWr && hit && (curMode == MODE_RESTART);
    strobes.cntInc      = !cntWr && running && !stopsCount;
    strobes.modeLoad    = modeWr;
    strobes.oneShotStop = !modeWr && hit && (curMode == MODE_ONESHOT);
    strobes.pendSet     = hit;
  end

endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tickStrobesT       strobes,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              matchHit,
  output tickModeE          curMode,
  output logic              irqReq,
  output logic [DATA_W-1:0] countVal,
  output logic [PERIOD_W-1:0] periodVal,
  output logic              pendVal,
  output logic              enVal
);

  localparam int PEND_BIT = PERIOD_W;
  localparam int EN_BIT   = PERIOD_W + 1;
  localparam int MODE_LSB = PERIOD_W + 2;

  logic [DATA_W-1:0]   countQ;
  logic [PERIOD_W-1:0] periodQ;
  logic                pendQ;
  logic                enQ;
  tickModeE            modeQ;
  logic [DATA_W-1:0]   modeWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (strobes.cntLoad) begin
      countQ <= regWrData;
    end else if (strobes.cntClear) begin
      countQ <= '0;
    end else if (strobes.cntInc) begin
      countQ <= countQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periodQ <= '0;
      enQ     <= 1'b0;
      modeQ   <= MODE_OFF;
    end else if (strobes.modeLoad) begin
      periodQ <= regWrData[PERIOD_W-1:0];
      enQ     <= regWrData[EN_BIT];
      modeQ   <= tickModeE'(regWrData[MODE_LSB +: 2]);
    end else if (strobes.oneShotStop) begin
      modeQ   <= MODE_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ <= 1'b0;
    end else if (strobes.pendSet) begin
      pendQ <= 1'b1;
    end else if (strobes.modeLoad) begin
      pendQ <= regWrData[PEND_BIT];
    end
  end

  always_comb begin
    modeWord                  = '0;
    modeWord[PERIOD_W-1:0]    = periodQ;
    modeWord[PEND_BIT]        = pendQ;
    modeWord[EN_BIT]          = enQ;
    modeWord[MODE_LSB +: 2]   = modeQ;
  end

  assign matchHit  = (countQ[PERIOD_W-1:0] == periodQ);
  assign regRdData = (regSel == SEL_MODE) ? modeWord : countQ;
  assign curMode   = modeQ;
  assign irqReq    = pendQ && enQ;
  assign countVal  = countQ;
  assign periodVal = periodQ;
  assign pendVal   = pendQ;
  assign enVal     = enQ;

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqReq
);

  tickStrobesT         strobes;
  tickModeE            curMode;
  logic                matchHit;
  logic [DATA_W-1:0]   countVal;
  logic [PERIOD_W-1:0] periodVal;
  logic                pendVal;
  logic                enVal;

  tick_timer_ctrl ctrl (
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .curMode  (curMode),
    .matchHit (matchHit),
    .strobes  (strobes)
  );

  tick_timer_datapath #(
    .DATA_W   (DATA_W),
    .PERIOD_W (PERIOD_W)
  ) dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .matchHit  (matchHit),
    .curMode   (curMode),
    .irqReq    (irqReq),
    .countVal  (countVal),
    .periodVal (periodVal),
    .pendVal   (pendVal),
    .enVal     (enVal)
  );

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                regWrEn,
  input logic                regSel,
  input logic [DATA_W-1:0]   regWrData,
  input logic                irqReq,
  input logic [DATA_W-1:0]   countVal,
  input logic [PERIOD_W-1:0] periodVal,
  input logic                pendVal,
  input logic                enVal,
  input logic [1:0]          modeVal
);

  logic cntWr;
  logic lowEq;
  assign cntWr = regWrEn && !regSel;
  assign lowEq = (countVal[PERIOD_W-1:0] == periodVal);

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cntWr |=> countVal == $past(regWrData)); // R9

  AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (modeVal == 2'b11 && !cntWr) |=> countVal == $past(countVal) + 1'b1); // R4

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (modeVal == 2'b00 && !cntWr) |=> $stable(countVal)); // R3

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (modeVal == 2'b01 && lowEq && !cntWr) |=> countVal == '0); // R5

  AST_ONESHOT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (modeVal == 2'b10 && lowEq && !regWrEn) |=> (modeVal == 2'b00 && $stable(countVal))); // R6

  AST_PEND_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (modeVal != 2'b00 && lowEq) |=> pendVal); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (pendVal && enVal)); // R7

endmodule

bind tick_timer_unit tick_timer_checker #(
  .DATA_W   (DATA_W),
  .PERIOD_W (PERIOD_W)
) chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regWrData (regWrData),
  .irqReq    (irqReq),
  .countVal  (countVal),
  .periodVal (periodVal),
  .pendVal   (pendVal),
  .enVal     (enVal),
  .modeVal   (curMode)
);

// File: tb/tick_timer_unit_test.sv
`timescale 1ns/100ps
module tick_timer_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqReq;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  typedef struct {
    int          kind;   // 0 count, 1 mode, 2 irq
    logic [31:0] expVal;
    string       tag;
  } sbItemT;

  sbItemT sbQ[$];
  event   sampleEv;

  always #2 clk = ~clk;

  tick_timer_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqReq    (irqReq)
  );

  initial begin
    forever begin
      @(sampleEv);
      while (sbQ.size() > 0) begin
        sbItemT it;
        logic [31:0] act;
        it = sbQ.pop_front();
        act = (it.kind == 2) ? {31'b0, irqReq} : regRdData;
        vecCount++;
        if (act !== it.expVal) begin
          errCount++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.expVal);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [31:0] expVal, input string tag);
    sbItemT it;
    it.kind = kind;
    it.expVal = expVal;
    it.tag = tag;
    if (kind != 2) regSel = (kind == 1);
    sbQ.push_back(it);
    #0.1;
    ->sampleEv;
    wait (sbQ.size() == 0);
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] data);
    regWrEn = 1'b1;
    regSel = sel;
    regWrData = data;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_item(0, 32'd0, "R1 count");
    expect_item(1, 32'd0, "R1 mode");
    expect_item(2, 32'd0, "R1 irq");
    edges(5);
    expect_item(0, 32'd0, "R3 held after reset");

    write_reg(1'b0, 32'd100);
    expect_item(0, 32'd100, "R9 count write");
    write_reg(1'b1, 32'hC000_0032);
    expect_item(0, 32'd100, "R3 held during mode write");
    edges(10);
    expect_item(0, 32'd110, "R2 increment");

    // match on low 28 bits with nonzero upper count bits
    write_reg(1'b1, 32'hC000_0019);
    write_reg(1'b0, 32'h3000_0014);
    edges(7);
    expect_item(0, 32'h3000_001B, "R4 runs through match");
    expect_item(1, 32'hD000_0019, "R4 pending from low-28 match");
    expect_item(2, 32'd0, "R7 irq gated by enable");

    write_reg(1'b1, 32'hE000_0019);
    expect_item(1, 32'hE000_0019, "R8 pending cleared on write");
    expect_item(2, 32'd0, "R8 irq low after clear");

    // next-event programming
    write_reg(1'b0, 32'd1000);
    write_reg(1'b1, 32'hE000_03F2);
    edges(9);
    expect_item(0, 32'd1010, "R4 count at match");
    expect_item(2, 32'd0, "R7 irq before pending");
    edges(1);
    expect_item(0, 32'd1011, "R4 continuous past match");
    expect_item(2, 32'd1, "R7 irq asserted");
    expect_item(1, 32'hF000_03F2, "R7 mode readback");

    write_reg(1'b1, 32'hC000_0000);
    expect_item(2, 32'd0, "R8 acknowledge");
    expect_item(1, 32'hC000_0000, "R8 mode after ack");
    expect_item(0, 32'd1012, "R8 counter keeps running");

    // match wins over same-cycle clear
    write_reg(1'b0, 32'd2000);
    write_reg(1'b1, 32'hC000_07D2);
    edges(1);
    write_reg(1'b1, 32'hC000_07D2);
    expect_item(1, 32'hD000_07D2, "R8 match beats clear");
    expect_item(0, 32'd2003, "R2 count");

    // restart mode
    write_reg(1'b1, 32'h4000_0005);
    write_reg(1'b0, 32'd0);
    edges(5);
    expect_item(0, 32'd5, "R5 count at match");
    edges(1);
    expect_item(0, 32'd0, "R5 restart to zero");
    expect_item(1, 32'h5000_0005, "R5 pending set");
    edges(1);
    expect_item(0, 32'd1, "R5 counts again");

    // disabled hold and period equal to frozen count
    write_reg(1'b1, 32'h0000_0000);
    expect_item(0, 32'd2, "R3 last step");
    write_reg(1'b0, 32'd300);
    edges(3);
    expect_item(0, 32'd300, "R3 held");
    expect_item(1, 32'h0000_0000, "R3 no match while off");
    write_reg(1'b1, 32'h8000_012C);
    expect_item(1, 32'h8000_012C, "R10 before detect");
    edges(1);
    expect_item(1, 32'h1000_012C, "R10 detected next clock");
    expect_item(0, 32'd300, "R6 frozen");
    edges(4);
    expect_item(0, 32'd300, "R6 stays frozen");

    // one-shot with interrupt
    write_reg(1'b0, 32'd500);
    write_reg(1'b1, 32'hA000_01F8);
    edges(4);
    expect_item(0, 32'd504, "R6 count reaches match");
    expect_item(2, 32'd0, "R6 irq not yet");
    edges(1);
    expect_item(0, 32'd504, "R6 stopped at match");
    expect_item(1, 32'h3000_01F8, "R6 mode self-disabled");
    expect_item(2, 32'd1, "R7 one-shot irq");
    write_reg(1'b1, 32'h0000_0000);
    expect_item(2, 32'd0, "R8 ack one-shot");

    // wrap
    write_reg(1'b1, 32'hCFFF_FFF0);
    write_reg(1'b0, 32'hFFFF_FFFE);
    edges(2);
    expect_item(0, 32'd0, "R2 wrap");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule